// File: doc/BRIEF.md
# Read Prefetch Boundary Controller

This block sits on the read path of a bus bridge, between the side that accepts a read from an initiator and the side that fetches data from the target. For each accepted read it works out how many DWORDs may be fetched ahead. It then issues one DWORD fetch request per clock, at consecutive DWORD addresses, until it reaches an aligned boundary. The boundary depends on the read command, on whether the address space is prefetchable, and on the programmed cache line size. In flow-through mode the boundary is instead the next 4 KB page edge.

Fetching stops early when the target asks to disconnect. In flow-through mode it also stops when the initiator drops FRAME#. The block counts the words the initiator consumes. When exactly one fetched word is still waiting and fetching is over, it tells the initiator-side logic to disconnect on that final data phase. If the initiator ends the transaction with words still unread, the block pulses a flush with the number of words to discard.

Top module: `rd_prefetch_ctl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy`, `fetch_valid`, `disc_last` and `flush` are low.
- R2: A configuration read (`req_cmd` 1010) or an I/O read (0010) fetches exactly one DWORD, whatever the cache line size.
- R3: A Memory Read (0110) to non-prefetchable space (`req_pref` low) fetches one DWORD. With `req_pref` high, the line size L is the `cache_line` value when that value is 1, 2, 4 or 8, and 16 for any other value. The read fetches L minus (start DWORD address mod L) words.
- R4: A Memory Read Line (1110) fetches like a prefetchable Memory Read, whatever `req_pref` is.
- R5: A Memory Read Multiple (1100) uses a block of 2L DWORDs: 32 when the cache line size is 0, 16 or unsupported, and twice the line otherwise.
- R6: A start address that is already on the block boundary fetches a whole block.
- R7: With `flow_mode` high at acceptance, a read of the prefetchable kind (R3 prefetchable, R4, R5) uses a 1024-DWORD (4 KB) block. A cycle in which `frame_on` is low ends fetching, and that cycle's word is not issued. A non-prefetchable read is unaffected.
- R8: A cycle with `tgt_stop` high while `fetch_valid` is high issues no word and ends fetching.
- R9: Fetch requests carry consecutive DWORD addresses starting at `req_dw`. In each cycle `fetch_valid` is high, one word is issued unless that cycle is stopped.
- R10: `disc_last` is high only when fetching is over, the block is busy, and exactly one fetched word has not yet been consumed.
- R11: An `init_end` pulse while busy ends the transaction. In the next cycle `busy` is low, and `flush` is high with `flush_cnt` equal to the unconsumed fetched words if that count is non-zero. `flush` stays low if the count is zero.
- R12: While busy, new requests are ignored. Command codes other than the five reads are ignored. `word_take` with no buffered word has no effect.
- R13: Once fetching is over and every fetched word has been consumed, `busy` falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New read request present |
| req_cmd | input | 4 | Bus command code |
| req_pref | input | 1 | Address lies in prefetchable space |
| req_dw | input | DW_W | Start DWORD address |
| cache_line | input | CLS_W | Programmed cache line size in DWORDs |
| flow_mode | input | 1 | Flow-through mode enabled |
| frame_on | input | 1 | Initiator still asserts FRAME# |
| tgt_stop | input | 1 | Target disconnect during fetch |
| word_take | input | 1 | Initiator consumes one buffered word |
| init_end | input | 1 | Initiator ended the transaction |
| busy | output | 1 | Transaction in progress |
| fetch_valid | output | 1 | Fetch request for `fetch_dw` |
| fetch_dw | output | DW_W | DWORD address of the fetch |
| disc_last | output | 1 | Next consumed word is the last; signal disconnect |
| flush | output | 1 | Discard unread words (one-cycle pulse) |
| flush_cnt | output | CNT_W | Number of words discarded, valid with `flush` |

## Verification
The bench targets boundary arithmetic where an off-by-one or wrong mask shows up as a miscounted burst. It covers starts exactly on a boundary, which must give a full block rather than zero words. It also covers an unsupported cache line value, which must fall back to 16, and the doubled block of Memory Read Multiple. Stop handling is probed at the cycle of a target disconnect or a FRAME# drop: a design that still counts that word issues one word too many. The final-word disconnect and the flush count are checked with words left in the buffer and with none. A design that drops the "none" case pulses a spurious flush of zero words.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
  typedef enum logic [3:0] {
    CMD_IORD  = 4'b0010,
    CMD_MRD   = 4'b0110,
    CMD_CFGRD = 4'b1010,
    CMD_MRM   = 4'b1100,
    CMD_MRL   = 4'b1110
  } rd_cmd_e;
endpackage

// File: rtl/rpf_len_calc.sv
module rpf_len_calc
  import rpf_pkg::*;
#(
  parameter int CLS_W    = 8,
  parameter int PAGE_DW  = 1024,
  parameter int DEF_LINE = 16,
  localparam int OFS_W   = $clog2(PAGE_DW),
  localparam int CNT_W   = OFS_W + 1
) (
  input  logic [3:0]       cmd,
  input  logic             pref,
  input  logic             flow,
  input  logic [OFS_W-1:0] ofs,
  input  logic [CLS_W-1:0] cls,
  output logic             cmd_ok,
  output logic             pf_class,
  output logic [CNT_W-1:0] len
);
  logic [CNT_W-1:0] line;
  logic [CNT_W-1:0] blk;
  logic [CNT_W-1:0] ofs_x;
  logic             line_ok;

  // only power-of-two sizes up to 8 are honoured; the rest fall back
  assign line_ok = (cls == CLS_W'(1)) || (cls == CLS_W'(2)) ||
                   (cls == CLS_W'(4)) || (cls == CLS_W'(8));

  always_comb begin
    line     = line_ok ? CNT_W'(cls) : CNT_W'(DEF_LINE);
    cmd_ok   = 1'b1;
    pf_class = 1'b0;
    blk      = line;
    case (cmd)
      CMD_IORD, CMD_CFGRD: pf_class = 1'b0;
      CMD_MRD:             pf_class = pref;
      CMD_MRL:             pf_class = 1'b1;
      CMD_MRM: begin
        pf_class = 1'b1;
        blk      = line << 1;
      end
      default:             cmd_ok = 1'b0;
    endcase
    if (flow) blk = CNT_W'(PAGE_DW);
    ofs_x = {1'b0, ofs};
    len   = pf_class ? (blk - (ofs_x & (blk - CNT_W'(1)))) : CNT_W'(1);
  end
endmodule

// File: rtl/rpf_fetch_seq.sv
module rpf_fetch_seq #(
  parameter int DW_W  = 30,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DW_W-1:0]  start_dw,
  input  logic [CNT_W-1:0] load_len,
  input  logic             stop,
  output logic             fetch_valid,
  output logic [DW_W-1:0]  fetch_dw,
  output logic [CNT_W-1:0] fetched
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_valid <= 1'b0;
      fetch_dw    <= '0;
      fetched     <= '0;
      remain      <= '0;
    end else if (load) begin
      fetch_valid <= 1'b1;
      fetch_dw    <= start_dw;
      fetched     <= '0;
      remain      <= load_len;
    end else if (fetch_valid) begin
      if (stop) begin
        fetch_valid <= 1'b0;
      end else begin
        fetched  <= fetched + CNT_W'(1);
        fetch_dw <= fetch_dw + DW_W'(1);
        remain   <= remain - CNT_W'(1);
        if (remain == CNT_W'(1)) fetch_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rpf_drain_track.sv
module rpf_drain_track #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             busy,
  input  logic             fetch_valid,
  input  logic [CNT_W-1:0] fetched,
  input  logic             word_take,
  input  logic             init_end,
  output logic             drained,
  output logic             disc_last,
  output logic             flush,
  output logic [CNT_W-1:0] flush_cnt
);
  logic [CNT_W-1:0] delivered;
  logic [CNT_W-1:0] deliv_nx;
  logic             take_ok;

  assign take_ok   = busy & word_take & (delivered < fetched);
  assign deliv_nx  = delivered + CNT_W'(take_ok);
  assign drained   = ~fetch_valid & (deliv_nx == fetched);
  assign disc_last = busy & ~fetch_valid & ((fetched - delivered) == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      delivered <= '0;
      flush     <= 1'b0;
      flush_cnt <= '0;
    end else begin
      flush <= 1'b0;
      if (load) begin
        delivered <= '0;
      end else if (busy) begin
        delivered <= deliv_nx;
        if (init_end) begin
          flush     <= (fetched != deliv_nx);
          flush_cnt <= fetched - deliv_nx;
        end
      end
    end
  end
endmodule

// File: rtl/rd_prefetch_ctl.sv
module rd_prefetch_ctl #(
  parameter int DW_W     = 30,
  parameter int CLS_W    = 8,
  parameter int PAGE_DW  = 1024,
  parameter int DEF_LINE = 16,
  localparam int OFS_W   = $clog2(PAGE_DW),
  localparam int CNT_W   = OFS_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [3:0]       req_cmd,
  input  logic             req_pref,
  input  logic [DW_W-1:0]  req_dw,
  input  logic [CLS_W-1:0] cache_line,
  input  logic             flow_mode,
  input  logic             frame_on,
  input  logic             tgt_stop,
  input  logic             word_take,
  input  logic             init_end,
  output logic             busy,
  output logic             fetch_valid,
  output logic [DW_W-1:0]  fetch_dw,
  output logic             disc_last,
  output logic             flush,
  output logic [CNT_W-1:0] flush_cnt
);
  logic             cmd_ok;
  logic             pf_class;
  logic [CNT_W-1:0] len;
  logic             accept;
  logic             ft_act;
  logic             stop;
  logic [CNT_W-1:0] fetched;
  logic             drained;

  rpf_len_calc #(
    .CLS_W(CLS_W), .PAGE_DW(PAGE_DW), .DEF_LINE(DEF_LINE)
  ) u_len (
    .cmd(req_cmd), .pref(req_pref), .flow(flow_mode),
    .ofs(req_dw[OFS_W-1:0]), .cls(cache_line),
    .cmd_ok(cmd_ok), .pf_class(pf_class), .len(len)
  );

  assign accept = req_valid & ~busy & cmd_ok;
  assign stop   = tgt_stop | init_end | (ft_act & ~frame_on);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      ft_act <= 1'b0;
    end else if (accept) begin
      busy   <= 1'b1;
      ft_act <= flow_mode & pf_class;
    end else if (busy & (init_end | drained)) begin
      busy   <= 1'b0;
    end
  end

  rpf_fetch_seq #(.DW_W(DW_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .load(accept), .start_dw(req_dw), .load_len(len),
    .stop(stop), .fetch_valid(fetch_valid), .fetch_dw(fetch_dw), .fetched(fetched)
  );

  rpf_drain_track #(.CNT_W(CNT_W)) u_drn (
    .clk(clk), .rst(rst), .load(accept), .busy(busy), .fetch_valid(fetch_valid),
    .fetched(fetched), .word_take(word_take), .init_end(init_end),
    .drained(drained), .disc_last(disc_last), .flush(flush), .flush_cnt(flush_cnt)
  );
endmodule

// File: rtl/rpf_checker.sv
module rpf_checker #(
  parameter int DW_W = 30
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            fetch_valid,
  input logic [DW_W-1:0] fetch_dw,
  input logic            tgt_stop,
  input logic            init_end,
  input logic            frame_on,
  input logic            disc_last,
  input logic            flush
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !fetch_valid && !flush && !disc_last));

  assert_addr_step_R9: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !tgt_stop && !init_end && frame_on) |=>
      (!fetch_valid || fetch_dw == $past(fetch_dw) + DW_W'(1)));

  assert_tgt_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && tgt_stop) |=> !fetch_valid);

  assert_disc_phase_R10: assert property (@(posedge clk) disable iff (rst)
    disc_last |-> (busy && !fetch_valid));

  assert_flush_idle_R11: assert property (@(posedge clk) disable iff (rst)
    flush |-> !busy);

  assert_fetch_busy_R12: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> busy);
endmodule

bind rd_prefetch_ctl rpf_checker #(.DW_W(DW_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .fetch_valid(fetch_valid),
  .fetch_dw(fetch_dw), .tgt_stop(tgt_stop), .init_end(init_end),
  .frame_on(frame_on), .disc_last(disc_last), .flush(flush)
);

// File: tb/tb_rd_prefetch_ctl.sv
`timescale 1ns/1ps
module tb_rd_prefetch_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_cmd = 4'b0;
  logic        req_pref = 1'b0;
  logic [29:0] req_dw = '0;
  logic [7:0]  cache_line = '0;
  logic        flow_mode = 1'b0;
  logic        frame_on = 1'b1;
  logic        tgt_stop = 1'b0;
  logic        word_take = 1'b0;
  logic        init_end = 1'b0;
  logic        busy, fetch_valid, disc_last, flush;
  logic [29:0] fetch_dw;
  logic [10:0] flush_cnt;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rd_prefetch_ctl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_pref(req_pref), .req_dw(req_dw), .cache_line(cache_line),
    .flow_mode(flow_mode), .frame_on(frame_on), .tgt_stop(tgt_stop),
    .word_take(word_take), .init_end(init_end), .busy(busy),
    .fetch_valid(fetch_valid), .fetch_dw(fetch_dw), .disc_last(disc_last),
    .flush(flush), .flush_cnt(flush_cnt)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_busy, m_fv, m_dw, m_rem, m_fet, m_del, m_ft, m_fl, m_fc;

  function automatic int ref_len(int cmd, int pref, int flow, int dw, int cls);
    int line, blk;
    line = (cls == 1 || cls == 2 || cls == 4 || cls == 8) ? cls : 16;
    case (cmd)
      2, 10: return 1;
      6: begin if (pref == 0) return 1; blk = line; end
      14: blk = line;
      12: blk = 2 * line;
      default: return 0;
    endcase
    if (flow != 0) blk = 1024;
    return blk - (dw % blk);
  endfunction

  always @(posedge clk) begin
    int take, nd, oldfv, oldfet, stp, fin, l;
    if (rst) begin
      m_busy = 0; m_fv = 0; m_dw = 0; m_rem = 0; m_fet = 0;
      m_del = 0; m_ft = 0; m_fl = 0; m_fc = 0;
    end else begin
      m_fl = 0;
      if (m_busy == 0) begin
        l = ref_len(int'(req_cmd), int'(req_pref), int'(flow_mode),
                    int'(req_dw), int'(cache_line));
        if (req_valid && l > 0) begin
          m_busy = 1; m_fv = 1; m_dw = int'(req_dw); m_rem = l;
          m_fet = 0; m_del = 0;
          m_ft = (flow_mode && (req_cmd == 4'b1110 || req_cmd == 4'b1100 ||
                  (req_cmd == 4'b0110 && req_pref))) ? 1 : 0;
        end
      end else begin
        take   = (word_take && m_del < m_fet) ? 1 : 0;
        nd     = m_del + take;
        oldfv  = m_fv;
        oldfet = m_fet;
        stp    = (tgt_stop || init_end || (m_ft != 0 && !frame_on)) ? 1 : 0;
        if (m_fv != 0) begin
          if (stp != 0) m_fv = 0;
          else begin
            m_fet++; m_dw++; m_rem--;
            if (m_rem == 0) m_fv = 0;
          end
        end
        fin = (init_end || (oldfv == 0 && nd == oldfet)) ? 1 : 0;
        if (init_end) begin
          m_fl = (oldfet != nd) ? 1 : 0;
          m_fc = oldfet - nd;
        end
        m_del = nd;
        if (fin != 0) m_busy = 0;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    int exp_disc;
    if (!rst && !done) begin
      exp_disc = (m_busy != 0 && m_fv == 0 && (m_fet - m_del) == 1) ? 1 : 0;
      chk(int'(busy) == m_busy, "R13", "busy", int'(busy), m_busy);
      chk(int'(fetch_valid) == m_fv, "R9", "fetch_valid", int'(fetch_valid), m_fv);
      if (m_fv != 0)
        chk(int'(fetch_dw) == m_dw, "R9", "fetch_dw", int'(fetch_dw), m_dw);
      chk(int'(disc_last) == exp_disc, "R10", "disc_last", int'(disc_last), exp_disc);
      chk(int'(flush) == m_fl, "R11", "flush", int'(flush), m_fl);
      if (m_fl != 0)
        chk(int'(flush_cnt) == m_fc, "R11", "flush_cnt", int'(flush_cnt), m_fc);
    end
  end

  // one transaction with a consuming initiator; counts issued words
  task automatic run(input logic [3:0] c, input bit p, input int dw, input int cl,
                     input bit fl, input int drop, input int stopat, input bit junk,
                     input int exp, input string tag);
    int cnt = 0;
    int g = 0;
    @(negedge clk);
    req_cmd = c; req_pref = p; req_dw = 30'(dw); cache_line = 8'(cl);
    flow_mode = fl; frame_on = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    if (junk) begin req_cmd = 4'b1010; req_dw = 30'(500); end
    else req_valid = 1'b0;
    word_take = 1'b1;
    while (busy && g < 3000) begin
      tgt_stop = 1'b0;
      if (fetch_valid) begin
        if (stopat >= 0 && cnt == stopat) tgt_stop = 1'b1;
        else if (drop >= 0 && cnt == drop) frame_on = 1'b0;
        else if (frame_on || !fl) cnt++;
      end
      @(negedge clk);
      g++;
    end
    tgt_stop = 1'b0; req_valid = 1'b0; word_take = 1'b0; frame_on = 1'b1;
    flow_mode = 1'b0;
    chk(g < 3000, "R13", "busy released after drain", g, 0);
    chk(cnt == exp, tag, "words fetched", cnt, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !fetch_valid && !flush, "R1", "idle during reset",
        int'(busy) + int'(fetch_valid) + int'(flush), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !fetch_valid && !disc_last && !flush, "R1", "idle after reset",
        int'(busy) + int'(fetch_valid), 0);

    run(4'b1010, 1, 256, 8, 0, -1, -1, 0, 1, "R2");    // config read
    run(4'b0010, 1, 7, 16, 0, -1, -1, 0, 1, "R2");     // I/O read
    run(4'b0110, 0, 3, 8, 0, -1, -1, 0, 1, "R3");      // MR non-prefetchable
    run(4'b0110, 1, 3, 8, 0, -1, -1, 0, 5, "R3");      // line 8, offset 3
    run(4'b0110, 1, 5, 0, 0, -1, -1, 0, 11, "R3");     // CLS 0 -> 16
    run(4'b0110, 1, 5, 3, 0, -1, -1, 0, 11, "R3");     // unsupported CLS -> 16
    run(4'b0110, 1, 20, 16, 0, -1, -1, 0, 12, "R3");   // CLS 16
    run(4'b1110, 0, 6, 4, 0, -1, -1, 0, 2, "R4");      // MRL ignores pref flag
    run(4'b1100, 0, 40, 0, 0, -1, -1, 0, 24, "R5");    // MRM 32-DWORD block
    run(4'b1100, 1, 1, 2, 0, -1, -1, 0, 3, "R5");      // MRM 2x line of 2
    run(4'b0110, 1, 8, 4, 0, -1, -1, 0, 4, "R6");      // aligned start
    run(4'b1100, 1, 64, 16, 0, -1, -1, 0, 32, "R6");   // aligned MRM
    run(4'b1110, 1, 1020, 4, 1, -1, -1, 0, 4, "R7");   // 4 KB edge
    run(4'b1110, 1, 0, 4, 1, 10, -1, 0, 10, "R7");     // FRAME# drop
    run(4'b0110, 0, 9, 8, 1, -1, -1, 0, 1, "R7");      // non-pref in flow mode
    run(4'b1100, 1, 0, 0, 0, -1, 5, 0, 5, "R8");       // target disconnect
    run(4'b1100, 1, 0, 0, 0, -1, -1, 1, 32, "R12");    // requests while busy

    // R12: unknown command is ignored
    @(negedge clk);
    req_cmd = 4'b0111; req_valid = 1'b1; req_pref = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!busy && !fetch_valid, "R12", "write command ignored", int'(busy), 0);

    // R10 / R11: hold the data, then drain partly and end early
    req_cmd = 4'b0110; req_pref = 1'b1; req_dw = 30'(0); cache_line = 8'(8);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (fetch_valid) @(negedge clk);
    chk(!disc_last, "R10", "no disconnect with 8 waiting", int'(disc_last), 0);
    word_take = 1'b1;
    repeat (6) @(negedge clk);
    word_take = 1'b0;
    chk(!disc_last, "R10", "no disconnect with 2 waiting", int'(disc_last), 0);
    word_take = 1'b1;
    @(negedge clk);
    word_take = 1'b0;
    chk(disc_last, "R10", "disconnect with 1 waiting", int'(disc_last), 1);
    init_end = 1'b1;
    @(negedge clk);
    init_end = 1'b0;
    chk(flush && flush_cnt == 11'd1, "R11", "flush one word", int'(flush_cnt), 1);
    chk(!busy && !disc_last, "R11", "idle after early end", int'(busy), 0);

    // R11: end before any word arrives -> no flush
    @(negedge clk);
    req_cmd = 4'b1100; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; init_end = 1'b1;
    @(negedge clk);
    init_end = 1'b0;
    chk(!flush && !busy, "R11", "no flush when nothing unread", int'(flush), 0);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R13 watchdog expired: got 1 expected 0");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule